// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a three-wire serial memory link. It drives chip-select, the serial clock and the serial data line toward a 512 x 16 non-volatile memory, and it samples the memory's data-out line through a synchronizer. A core-side request names an operation, a 9-bit word address, 16 bits of write data and a word count for reads. The controller builds the serial frame and clocks it out. For reads it returns one word per `rd_valid` pulse. Every command ends with a single `done` pulse.

The serial clock comes from the system clock: each bit spends `HALF_CYC` cycles low and then `HALF_CYC` cycles high. Data-in changes only when the serial clock falls. A configurable number of dummy clocks, with data-in held low, can go ahead of the start bit.

After a command that programs the memory (write, erase, write-all, erase-all), the controller drops chip-select for the minimum deselect time, which starts the internal write. It then raises chip-select again, holds the clock and data-in low, and waits for data-out to go low and then high. If that change does not arrive within `POLL_LIMIT` cycles, the command is abandoned and a timeout is reported.

Top module: `eectl_host`

## Requirements
- R1: After synchronous reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done`, `timeout` and `rd_valid` are all low.
- R2: Request codes are 0 read, 1 write, 2 erase, 3 write-all and 4 erase-all. Each frame is a start bit of 1, then a two-bit opcode (read 10, write 01, erase 11, write-all and erase-all 00), then a 10-bit field. For read, write and erase the field is a 0 followed by the address, MSB first. For write-all the field is 01 followed by eight 0s; for erase-all it is 10 followed by eight 0s.
- R3: Each serial bit holds `ee_sk` low for `HALF_CYC` cycles and then high for `HALF_CYC` cycles, with `ee_cs` high. `ee_di` changes only when `ee_sk` falls and is stable while `ee_sk` is high. `ee_sk` is low whenever `ee_cs` is low.
- R4: `DUMMY_CLKS` serial clocks with `ee_di` low come before the start bit.
- R5: Write and write-all frames carry 16 data bits after the field, D15 first. Read, erase and erase-all frames carry no data bits.
- R6: A read sends `req_len+1` words' worth of clocks after the field, with `ee_di` low. The bit returned on the last field clock is discarded. The next 16 clocks form one word, MSB first, which is presented on `rd_data` with a one-cycle `rd_valid` pulse, and so on for each further word. The words come from consecutive addresses, and address 511 is followed by address 0.
- R7: After every frame, `ee_cs` stays low for exactly `DESEL_CYC` cycles before it is raised again or before `done`.
- R8: After the deselect that follows a programming frame, `ee_cs` is high with `ee_sk` and `ee_di` low. This lasts until synchronized data-out has been seen at 0 and then at 1. Another deselect of `DESEL_CYC` cycles follows, and then `done`.
- R9: If the low-to-high change of R8 has not happened after `POLL_LIMIT` cycles of polling, `ee_cs` drops, and after the deselect time `timeout` pulses in the same cycle as `done`.
- R10: `busy` rises in the cycle after a request is accepted and stays high until the cycle of `done`. Requests that arrive while `busy` is high, and requests with codes 5 to 7, are ignored.
- R11: `done` is a one-cycle pulse, asserted in the first cycle with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_op | input | 3 | Operation code (0..4) |
| req_addr | input | 9 | Word address |
| req_wdata | input | 16 | Data for write and write-all |
| req_len | input | LEN_W | Read length minus one, in words |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Pulses with `done` when polling expired |
| rd_valid | output | 1 | One-cycle pulse per read word |
| rd_data | output | 16 | Read word, valid with `rd_valid` |
| ee_cs | output | 1 | Memory chip-select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data and ready status from the memory |

## Verification
The assertions assume that `rst` is applied before the first request. They also assume that the memory changes `ee_do` no later than the serial-clock rise that launches a bit, because the two-stage synchronizer needs `HALF_CYC` of at least 3 to present that bit before the clock falls. The bench meets both conditions by using a behavioural memory model that updates its output on the rising serial clock and reports busy as a 0 while chip-select is high. Request fields are free to change while `busy` is high, and the bench does change them, because the controller latches everything it needs at acceptance.

// File: rtl/eectl_pkg.sv
package eectl_pkg;

    localparam int ADDR_W  = 9;
    localparam int WORD_W  = 16;
    localparam int FIELD_W = ADDR_W + 1;
    localparam int HDR_W   = 1 + 2 + FIELD_W;
    localparam int FRAME_W = HDR_W + WORD_W;
    localparam int WB_W    = $clog2(WORD_W);

    typedef enum logic [2:0] {
        CMD_READ  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_ERASE = 3'd2,
        CMD_WRALL = 3'd3,
        CMD_ERALL = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_DESEL,
        ST_POLL
    } state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic               has_data;
        logic               is_read;
        logic               is_prog;
    } frame_t;

    function automatic logic cmd_known(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

endpackage

// File: rtl/eectl_framer.sv
module eectl_framer
    import eectl_pkg::*;
(
    input  cmd_e                cmd,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output frame_t              frm
);

    logic [1:0]         opc;
    logic [FIELD_W-1:0] fld;
    logic               with_data;

    always_comb begin
        opc       = 2'b00;
        fld       = '0;
        with_data = 1'b0;
        frm       = '0;
        unique case (cmd)
            CMD_READ: begin
                opc = 2'b10;
                fld = {1'b0, addr};
                frm.is_read = 1'b1;
            end
            CMD_WRITE: begin
                opc = 2'b01;
                fld = {1'b0, addr};
                with_data = 1'b1;
                frm.is_prog = 1'b1;
            end
            CMD_ERASE: begin
                opc = 2'b11;
                fld = {1'b0, addr};
                frm.is_prog = 1'b1;
            end
            CMD_WRALL: begin
                fld = {2'b01, {(FIELD_W-2){1'b0}}};
                with_data = 1'b1;
                frm.is_prog = 1'b1;
            end
            CMD_ERALL: begin
                fld = {2'b10, {(FIELD_W-2){1'b0}}};
                frm.is_prog = 1'b1;
            end
            default: ;
        endcase
        frm.has_data = with_data;
        frm.bits     = {1'b1, opc, fld, (with_data ? wdata : {WORD_W{1'b0}})};
    end

endmodule

// File: rtl/eectl_sk_timer.sv
module eectl_sk_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sk,
    output logic half_end
);

    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt;

    assign half_end = run && (cnt == CW'(HALF_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            sk  <= 1'b0;
        end else if (half_end) begin
            cnt <= '0;
            sk  <= ~sk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/eectl_sync.sv
module eectl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    generate
        if (STAGES <= 1) begin : g_single
            logic r;
            always_ff @(posedge clk) begin
                if (rst) r <= 1'b1;
                else     r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] r;
            always_ff @(posedge clk) begin
                if (rst) r <= '1;
                else     r <= {r[STAGES-2:0], d};
            end
            assign q = r[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/eectl_host.sv
module eectl_host
    import eectl_pkg::*;
#(
    parameter int HALF_CYC   = 4,
    parameter int DUMMY_CLKS = 0,
    parameter int DESEL_CYC  = 4,
    parameter int POLL_LIMIT = 600000,
    parameter int LEN_W      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);

    localparam int MAX_BITS = DUMMY_CLKS + HDR_W + WORD_W * (2 ** LEN_W);
    localparam int BC_W     = $clog2(MAX_BITS + 1);
    localparam int DC_W     = $clog2(DUMMY_CLKS + 2);
    localparam int GC_W     = $clog2(DESEL_CYC + 1);
    localparam int PC_W     = $clog2(POLL_LIMIT + 1);
    localparam int SKIP     = DUMMY_CLKS + HDR_W;

    state_e              state;
    frame_t              frm;
    logic [BC_W-1:0]     tot_bits;
    logic                accept;
    logic                half_end;
    logic                end_high;
    logic                do_s;

    logic [FRAME_W-1:0]  sh;
    logic [DC_W-1:0]     dummy_left;
    logic [BC_W-1:0]     bits_left;
    logic [BC_W-1:0]     bits_done;
    logic                cur_read;
    logic                cur_prog;
    logic                polled;
    logic                to_flag;
    logic                seen_low;
    logic [GC_W-1:0]     gcnt;
    logic [PC_W-1:0]     pcnt;
    logic [WORD_W-2:0]   rd_sh;
    logic [WB_W-1:0]     wbit;

    eectl_framer u_framer (
        .cmd   (cmd_e'(req_op)),
        .addr  (req_addr),
        .wdata (req_wdata),
        .frm   (frm)
    );

    eectl_sk_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (state == ST_SHIFT),
        .sk       (ee_sk),
        .half_end (half_end)
    );

    eectl_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ee_do),
        .q   (do_s)
    );

    assign end_high = half_end && ee_sk;
    assign accept   = req_valid && (state == ST_IDLE) && cmd_known(req_op);
    assign busy     = (state != ST_IDLE);

    always_comb begin
        tot_bits = BC_W'(DUMMY_CLKS + HDR_W);
        if (frm.has_data)
            tot_bits = tot_bits + BC_W'(WORD_W);
        if (frm.is_read)
            tot_bits = tot_bits + BC_W'(WORD_W) * (BC_W'(req_len) + BC_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            ee_cs      <= 1'b0;
            ee_di      <= 1'b0;
            sh         <= '0;
            dummy_left <= '0;
            bits_left  <= '0;
            bits_done  <= '0;
            cur_read   <= 1'b0;
            cur_prog   <= 1'b0;
            polled     <= 1'b0;
            to_flag    <= 1'b0;
            seen_low   <= 1'b0;
            gcnt       <= '0;
            pcnt       <= '0;
            rd_sh      <= '0;
            wbit       <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            done       <= 1'b0;
            timeout    <= 1'b0;
        end else begin
            done     <= 1'b0;
            timeout  <= 1'b0;
            rd_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state      <= ST_SHIFT;
                        ee_cs      <= 1'b1;
                        cur_read   <= frm.is_read;
                        cur_prog   <= frm.is_prog;
                        polled     <= 1'b0;
                        to_flag    <= 1'b0;
                        bits_left  <= tot_bits;
                        bits_done  <= '0;
                        wbit       <= '0;
                        dummy_left <= DC_W'(DUMMY_CLKS);
                        if (DUMMY_CLKS == 0) begin
                            ee_di <= frm.bits[FRAME_W-1];
                            sh    <= frm.bits << 1;
                        end else begin
                            ee_di <= 1'b0;
                            sh    <= frm.bits;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (end_high) begin
                        bits_done <= bits_done + 1'b1;
                        if (cur_read && (bits_done >= BC_W'(SKIP))) begin
                            rd_sh <= {rd_sh[WORD_W-3:0], do_s};
                            wbit  <= wbit + 1'b1;
                            if (wbit == WB_W'(WORD_W - 1)) begin
                                rd_valid <= 1'b1;
                                rd_data  <= {rd_sh, do_s};
                            end
                        end
                        if (bits_left == BC_W'(1)) begin
                            state <= ST_DESEL;
                            ee_cs <= 1'b0;
                            ee_di <= 1'b0;
                            gcnt  <= '0;
                        end else begin
                            bits_left <= bits_left - 1'b1;
                            if (dummy_left > DC_W'(1)) begin
                                dummy_left <= dummy_left - 1'b1;
                                ee_di      <= 1'b0;
                            end else begin
                                dummy_left <= '0;
                                ee_di      <= sh[FRAME_W-1];
                                sh         <= sh << 1;
                            end
                        end
                    end
                end
                ST_DESEL: begin
                    if (gcnt == GC_W'(DESEL_CYC - 1)) begin
                        if (cur_prog && !polled) begin
                            state    <= ST_POLL;
                            ee_cs    <= 1'b1;
                            polled   <= 1'b1;
                            pcnt     <= '0;
                            seen_low <= 1'b0;
                        end else begin
                            state   <= ST_IDLE;
                            done    <= 1'b1;
                            timeout <= to_flag;
                        end
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                ST_POLL: begin
                    if (!do_s)
                        seen_low <= 1'b1;
                    if (seen_low && do_s) begin
                        state <= ST_DESEL;
                        ee_cs <= 1'b0;
                        gcnt  <= '0;
                    end else if (pcnt == PC_W'(POLL_LIMIT - 1)) begin
                        state   <= ST_DESEL;
                        ee_cs   <= 1'b0;
                        gcnt    <= '0;
                        to_flag <= 1'b1;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/eectl_chk.sv
module eectl_chk #(
    parameter int DESEL_CYC = 4
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic timeout,
    input logic rd_valid,
    input logic ee_cs,
    input logic ee_sk,
    input logic ee_di
);

    localparam int LW = $clog2(DESEL_CYC + 1);

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            low_cnt <= LW'(DESEL_CYC);
        else if (ee_cs)
            low_cnt <= '0;
        else if (low_cnt < LW'(DESEL_CYC))
            low_cnt <= low_cnt + 1'b1;
    end

    // R3
    sk_parked_chk: assert property (@(posedge clk) disable iff (rst)
        !ee_cs |-> !ee_sk);

    // R3
    di_steady_chk: assert property (@(posedge clk) disable iff (rst)
        ee_sk |-> $stable(ee_di));

    // R7
    desel_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ee_cs) |-> (low_cnt >= LW'(DESEL_CYC)));

    // R10
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    timeout_cs_chk: assert property (@(posedge clk) disable iff (rst)
        timeout |-> (done && !ee_cs));

    // R6
    rdv_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> busy);

endmodule

bind eectl_host eectl_chk #(.DESEL_CYC(DESEL_CYC)) u_eectl_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .timeout   (timeout),
    .rd_valid  (rd_valid),
    .ee_cs     (ee_cs),
    .ee_sk     (ee_sk),
    .ee_di     (ee_di)
);

// File: tb/test_eectl_host.sv
module test_eectl_host;
    import eectl_pkg::*;

    localparam int CLK_NS = 10;
    localparam int HALF   = 4;
    localparam int NDUM   = 2;
    localparam int GAP    = 5;
    localparam int PLIM   = 3000;
    localparam int LEN_W  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [8:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic busy, done, timeout, rd_valid;
    logic [15:0] rd_data;
    logic ee_cs, ee_sk, ee_di, ee_do;

    always #(CLK_NS/2) clk = ~clk;

    eectl_host #(
        .HALF_CYC(HALF), .DUMMY_CLKS(NDUM), .DESEL_CYC(GAP),
        .POLL_LIMIT(PLIM), .LEN_W(LEN_W)
    ) i_eectl_host (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
        .busy(busy), .done(done), .timeout(timeout), .rd_valid(rd_valid),
        .rd_data(rd_data), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
        .ee_do(ee_do)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [15:0] mem     [512];
    logic [15:0] exp_mem [512];
    int   cyc = 0;
    int   busy_until = 0;
    int   m_busy_len = 300;
    bit   m_start = 0, m_rd = 0, m_dout = 0;
    int   m_nb = 0, m_rbit = 0;
    logic [11:0] m_cmd = '0;
    logic [15:0] m_dsh = '0;
    logic [8:0]  m_raddr = '0;
    wire  m_busy = (cyc < busy_until);

    always @(posedge clk) cyc <= cyc + 1;

    assign ee_do = !ee_cs ? 1'b1 : (m_busy ? 1'b0 : (m_rd ? m_dout : 1'b1));

    always @(posedge ee_sk or negedge ee_cs) begin
        if (!ee_cs) begin
            if (m_start && !m_rd && m_nb >= 12 && !m_busy) begin
                case (m_cmd[11:10])
                    2'b01: if (m_nb >= 28) begin
                        mem[m_cmd[8:0]] = m_dsh; busy_until = cyc + m_busy_len;
                    end
                    2'b11: begin
                        mem[m_cmd[8:0]] = 16'hFFFF; busy_until = cyc + m_busy_len;
                    end
                    2'b00: if (m_cmd[9:8] == 2'b01 && m_nb >= 28) begin
                        for (int i = 0; i < 512; i++) mem[i] = m_dsh;
                        busy_until = cyc + m_busy_len;
                    end else if (m_cmd[9:8] == 2'b10) begin
                        for (int i = 0; i < 512; i++) mem[i] = 16'hFFFF;
                        busy_until = cyc + m_busy_len;
                    end
                    default: ;
                endcase
            end
            m_start = 0; m_rd = 0; m_nb = 0;
        end else if (!m_busy) begin
            if (!m_start) begin
                if (ee_di) begin m_start = 1; m_nb = 0; end
            end else begin
                m_nb++;
                if (m_nb <= 12) begin
                    m_cmd = {m_cmd[10:0], ee_di};
                    if (m_nb == 12 && m_cmd[11:10] == 2'b10) begin
                        m_rd = 1; m_raddr = m_cmd[8:0]; m_dout = 0; m_rbit = 0;
                    end
                end else if (m_rd) begin
                    m_dout = mem[m_raddr][15-m_rbit];
                    m_rbit++;
                    if (m_rbit == 16) begin m_rbit = 0; m_raddr = m_raddr + 9'd1; end
                end else begin
                    m_dsh = {m_dsh[14:0], ee_di};
                end
            end
        end
    end

    // ---------------- reference sequencer, compared every clock ----------------
    task automatic run_cmd(input int op, input int addr, input int data,
                           input int len, input bit poke, input bit exp_to);
        bit q[$];
        logic [1:0] opc;
        logic [9:0] fld;
        bit pend;
        int widx;
        int n;
        bit prog;
        logic [15:0] ew;
        q = {};
        case (op)
            0: opc = 2'b10;
            1: opc = 2'b01;
            2: opc = 2'b11;
            default: opc = 2'b00;
        endcase
        if (op == 3)      fld = 10'b01_0000_0000;
        else if (op == 4) fld = 10'b10_0000_0000;
        else              fld = {1'b0, addr[8:0]};
        repeat (NDUM) q.push_back(1'b0);
        q.push_back(1'b1);
        q.push_back(opc[1]); q.push_back(opc[0]);
        for (int i = 9; i >= 0; i--) q.push_back(fld[i]);
        if (op == 1 || op == 3)
            for (int i = 15; i >= 0; i--) q.push_back(data[i]);
        if (op == 0)
            repeat (16 * (len + 1)) q.push_back(1'b0);
        prog = (op != 0);

        @(negedge clk);
        req_valid = 1'b1; req_op = 3'(op); req_addr = 9'(addr);
        req_wdata = 16'(data); req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~req_addr; req_wdata = ~req_wdata;
        pend = 0; widx = 0;

        for (int b = 0; b < q.size(); b++) begin
            for (int h = 0; h < 2 * HALF; h++) begin
                req_valid = (poke && b == 3 && h == 0);
                if (req_valid) req_op = 3'd4;
                chk(ee_cs === 1'b1, "R3", "cs in frame", ee_cs, 1);
                chk(ee_sk === (h >= HALF), "R3", "sk phase", ee_sk, (h >= HALF));
                if (b < NDUM)
                    chk(ee_di === 1'b0, "R4", "dummy di", ee_di, 0);
                else if (b >= NDUM + 13)
                    chk(ee_di === q[b], "R5", "data/tail di", ee_di, q[b]);
                else
                    chk(ee_di === q[b], "R2", "header di", ee_di, q[b]);
                chk(busy === 1'b1, "R10", "busy in frame", busy, 1);
                chk(done === 1'b0, "R11", "done in frame", done, 0);
                chk(rd_valid === pend, "R6", "rd_valid", rd_valid, pend);
                if (pend) begin
                    ew = exp_mem[(addr + widx) % 512];
                    chk(rd_data === ew, "R6", "rd_data", rd_data, ew);
                    widx++;
                end
                pend = (op == 0 && h == 2 * HALF - 1 && b >= NDUM + 13 &&
                        ((b - NDUM - 13) % 16) == 15);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;

        for (int g = 0; g < GAP; g++) begin
            chk(ee_cs === 1'b0 && ee_sk === 1'b0, "R7", "deselect", ee_cs, 0);
            chk(busy === 1'b1 && done === 1'b0, "R10", "busy in deselect", busy, 1);
            chk(rd_valid === pend, "R6", "rd_valid tail", rd_valid, pend);
            if (pend) begin
                ew = exp_mem[(addr + widx) % 512];
                chk(rd_data === ew, "R6", "rd_data tail", rd_data, ew);
                widx++;
            end
            pend = 0;
            @(negedge clk);
        end
        if (op == 0)
            chk(widx == len + 1, "R6", "word count", widx, len + 1);

        if (prog) begin
            n = 0;
            while (ee_cs === 1'b1 && n < PLIM + 20) begin
                chk(ee_sk === 1'b0 && ee_di === 1'b0, "R8", "poll pins",
                    {ee_sk, ee_di}, 0);
                chk(busy === 1'b1, "R10", "busy in poll", busy, 1);
                n++;
                @(negedge clk);
            end
            if (exp_to)
                chk(n == PLIM, "R9", "poll length", n, PLIM);
            else
                chk(n >= m_busy_len - GAP - 1 && n < PLIM, "R8", "poll length",
                    n, m_busy_len);
            for (int g = 0; g < GAP; g++) begin
                chk(ee_cs === 1'b0 && ee_sk === 1'b0, "R7", "post-poll deselect",
                    ee_cs, 0);
                chk(done === 1'b0, "R11", "early done", done, 0);
                @(negedge clk);
            end
        end

        chk(done === 1'b1, "R11", "done pulse", done, 1);
        chk(busy === 1'b0, "R10", "busy at done", busy, 0);
        chk(timeout === exp_to, exp_to ? "R9" : "R8", "timeout flag", timeout, exp_to);
        @(negedge clk);
        chk(done === 1'b0, "R11", "done width", done, 0);

        case (op)
            1: exp_mem[addr] = 16'(data);
            2: exp_mem[addr] = 16'hFFFF;
            3: for (int i = 0; i < 512; i++) exp_mem[i] = 16'(data);
            4: for (int i = 0; i < 512; i++) exp_mem[i] = 16'hFFFF;
            default: ;
        endcase
    endtask

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i] = 16'hFFFF;
            exp_mem[i] = 16'hFFFF;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ee_cs === 0 && ee_sk === 0 && ee_di === 0, "R1", "pins after reset",
            {ee_cs, ee_sk, ee_di}, 0);
        chk(busy === 0 && done === 0 && timeout === 0 && rd_valid === 0, "R1",
            "status after reset", {busy, done, timeout, rd_valid}, 0);

        run_cmd(1, 9'h012, 16'hA5C3, 0, 1'b1, 1'b0);   // write, with refused poke (R10)
        run_cmd(0, 9'h012, 0, 0, 1'b0, 1'b0);          // read back
        run_cmd(1, 9'h013, 16'h0F1E, 0, 1'b0, 1'b0);
        run_cmd(0, 9'h011, 0, 2, 1'b0, 1'b0);          // three-word burst
        run_cmd(2, 9'h012, 0, 0, 1'b0, 1'b0);          // erase
        run_cmd(0, 9'h012, 0, 0, 1'b0, 1'b0);
        run_cmd(1, 9'h1FF, 16'h1234, 0, 1'b0, 1'b0);
        run_cmd(1, 9'h000, 16'h5678, 0, 1'b0, 1'b0);
        run_cmd(0, 9'h1FF, 0, 1, 1'b0, 1'b0);          // R6 wrap 511 -> 0
        run_cmd(3, 9'h0AB, 16'hC0DE, 0, 1'b0, 1'b0);   // write-all
        run_cmd(0, 9'h064, 0, 1, 1'b0, 1'b0);
        run_cmd(4, 9'h000, 0, 0, 1'b0, 1'b0);          // erase-all
        run_cmd(0, 9'h005, 0, 0, 1'b0, 1'b0);

        // R10 unknown request code is not accepted
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd6;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(busy === 1'b0 && ee_cs === 1'b0, "R10", "code 6 ignored",
                {busy, ee_cs}, 0);
            @(negedge clk);
        end

        // R9 memory never reports ready within the poll limit
        m_busy_len = 100000;
        run_cmd(1, 9'h033, 16'hBEEF, 0, 1'b0, 1'b1);
        chk(ee_cs === 1'b0, "R9", "cs low after timeout", ee_cs, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule